// File: doc/BRIEF.md
# Single-Pin GPIO Slice with Debounce and Interrupt Detection

This block controls one general-purpose I/O pin. Software reaches it through a small word-wide register window: a configuration word, a debounce threshold, a readable input level, a float control, a drive value and a write-only interrupt clear. The slice drives the pad, or leaves it floating. It brings the pad input into the clock domain through a two-flop synchroniser. An optional filter follows, counting millisecond tick strobes.

The filtered level feeds an event detector. Per configuration, the detector either ignores the pin, watches for an active level, watches for one edge direction, or watches for both edges. A detected event sets a pending flag. The interrupt line is that flag gated by the interrupt enable and the pin enable. Edge events stay pending until software clears them. A level event keeps re-asserting the flag for as long as the level holds.

Top module: `gpio_slice`

## Requirements
- R1: After reset every register reads 0, and pad_o, pad_oe and irq are 0.
- R2: Writes land in the configuration word at 0x00 (bit 0 pin enable, bit 1 output direction, bits 3:2 trigger mode, bit 4 polarity, bit 5 debounce enable, bit 6 interrupt enable). They also land in the threshold at 0x04 (bits 7:0), the float bit at 0x0C bit 0 and the drive value at 0x10 bit 0. Each reads back one cycle after its address is presented.
- R3: pad_oe is 1 only when the pin is enabled, the direction is output and the float bit is 0. pad_o follows the drive value.
- R4: Offset 0x08 bit 0 returns the filtered pad level. With debounce disabled, or with a threshold of 0, the filtered level follows the synchronised pad directly.
- R5: With debounce enabled and a nonzero threshold N, the filtered level changes only after the synchronised pad has differed from it for N tick strobes. Returning to the filtered level restarts the count.
- R6: Trigger mode 2 (single edge) detects a rising edge when polarity is 1 and a falling edge when polarity is 0. The opposite edge is ignored.
- R7: Trigger mode 3 detects both rising and falling edges.
- R8: Trigger mode 1 (level) detects a high level when polarity is 1 and a low level when polarity is 0. While that level holds, a clear leaves the flag set. Once the level is gone, the flag stays set until a clear.
- R9: Writing 0x14 with bit 0 = 1 clears an edge-pending flag. Writing 0x14 with bit 0 = 0 has no effect.
- R10: irq equals the pending flag ANDed with interrupt enable and pin enable. Trigger mode 0 never sets the flag. A flag set while the interrupt is masked appears on irq once the interrupt is unmasked.
- R11: While the pin enable is 0, no event is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| pad_in | input | 1 | Asynchronous pad input level |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| pad_o | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take bus_wr to be a clean one-cycle-wide strobe. They take tick_1ms to be a single-cycle pulse, and pad_in to be held long enough to cross the two-flop synchroniser. The debounce hold property also assumes the configuration word and the threshold do not change in the same cycle that a tick arrives. The stimulus keeps to these conditions. It changes the pad and the registers only on falling clock edges. It lets several idle cycles pass after each pad change, so the synchroniser settles before any tick is issued. It also issues ticks only while the configuration is steady.

// File: rtl/gpio_slice_pkg.sv
package gpio_slice_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // LSB first in the word: pin_en is bit 0, irq_en is bit 6
  typedef struct packed {
    logic  irq_en;
    logic  deb_en;
    logic  pol;
    trig_e mode;
    logic  dir_out;
    logic  pin_en;
  } cfg_t;

  localparam int unsigned CFG_W    = $bits(cfg_t);
  localparam int unsigned OFS_CFG  = 'h00;
  localparam int unsigned OFS_DBC  = 'h04;
  localparam int unsigned OFS_IN   = 'h08;
  localparam int unsigned OFS_OCTL = 'h0C;
  localparam int unsigned OFS_OVAL = 'h10;
  localparam int unsigned OFS_CLR  = 'h14;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_slice_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              filt,
  output cfg_t              cfg,
  output logic [THR_W-1:0]  thr,
  output logic              float_q,
  output logic              oval_q,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);

  function automatic logic hit(input int unsigned ofs);
    return addr == ADDR_W'(ofs);
  endfunction

  assign clr = wr && hit(OFS_CLR) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      thr     <= '0;
      float_q <= 1'b0;
      oval_q  <= 1'b0;
    end else if (wr) begin
      if (hit(OFS_CFG))  cfg     <= cfg_t'(wdata[CFG_W-1:0]);
      if (hit(OFS_DBC))  thr     <= wdata[THR_W-1:0];
      if (hit(OFS_OCTL)) float_q <= wdata[0];
      if (hit(OFS_OVAL)) oval_q  <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (hit(OFS_CFG)) begin
      rdata <= DATA_W'(cfg);
    end else if (hit(OFS_DBC)) begin
      rdata <= DATA_W'(thr);
    end else if (hit(OFS_IN)) begin
      rdata <= DATA_W'(filt);
    end else if (hit(OFS_OCTL)) begin
      rdata <= DATA_W'(float_q);
    end else if (hit(OFS_OVAL)) begin
      rdata <= DATA_W'(oval_q);
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int THR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pad_raw,
  input  logic             tick,
  input  logic             deb_en,
  input  logic [THR_W-1:0] thr,
  output logic             filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [THR_W-1:0]       cnt_q;
  logic                   level_s;

  assign level_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt  <= 1'b0;
      cnt_q <= '0;
    end else if (!deb_en || thr == '0) begin
      filt  <= level_s;
      cnt_q <= '0;
    end else if (level_s == filt) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= thr - 1'b1) begin
        filt  <= level_s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_event.sv
module gpio_event
  import gpio_slice_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic filt,
  input  cfg_t cfg,
  input  logic clr,
  output logic pend
);

  logic prev_q;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= filt;
  end

  always_comb begin
    hit = 1'b0;
    if (cfg.pin_en) begin
      unique case (cfg.mode)
        TRIG_LEVEL: hit = (filt == cfg.pol);
        TRIG_EDGE:  hit = cfg.pol ? (filt & ~prev_q) : (~filt & prev_q);
        TRIG_BOTH:  hit = filt ^ prev_q;
        default:    hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~clr) | hit;
  end

endmodule

// File: rtl/gpio_slice.sv
module gpio_slice
  import gpio_slice_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int THR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pad_in,
  input  logic              tick_1ms,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              irq
);

  cfg_t             cfg_q;
  logic [THR_W-1:0] thr_q;
  logic             float_q;
  logic             oval_q;
  logic             clr_pulse;
  logic             filt_lvl;
  logic             pend_q;

  gpio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .filt(filt_lvl), .cfg(cfg_q), .thr(thr_q), .float_q(float_q),
    .oval_q(oval_q), .clr(clr_pulse), .rdata(bus_rdata)
  );

  gpio_debounce #(.THR_W(THR_W), .SYNC_STAGES(SYNC_STAGES)) u_deb (
    .clk(clk), .rst(rst), .pad_raw(pad_in), .tick(tick_1ms),
    .deb_en(cfg_q.deb_en), .thr(thr_q), .filt(filt_lvl)
  );

  gpio_event u_evt (
    .clk(clk), .rst(rst), .filt(filt_lvl), .cfg(cfg_q),
    .clr(clr_pulse), .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
      irq    <= 1'b0;
    end else begin
      pad_o  <= oval_q;
      pad_oe <= cfg_q.pin_en & cfg_q.dir_out & ~float_q;
      irq    <= pend_q & cfg_q.irq_en & cfg_q.pin_en;
    end
  end

endmodule

// File: rtl/gpio_slice_chk.sv
module gpio_slice_chk
  import gpio_slice_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int THR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tick_1ms,
  input logic              pad_oe,
  input logic              irq,
  input logic              pend,
  input logic              filt,
  input logic              clr,
  input cfg_t              cfg,
  input logic [THR_W-1:0]  thr
);

  // R3: setting the float bit removes the drive two edges later
  a_r3_float_drops_oe: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_OCTL) && bus_wdata[0]) |-> ##2 !pad_oe);

  // R5: with an active filter and no tick the filtered level holds
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (cfg.deb_en && thr != '0 && !tick_1ms) |=> $stable(filt));

  // R8: an active level keeps the flag set on the next cycle
  a_r8_level_keeps_pend: assert property (@(posedge clk) disable iff (rst)
    (cfg.pin_en && cfg.mode == TRIG_LEVEL && filt == cfg.pol) |=> pend);

  // R9: the flag only falls after a clear write
  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(clr));

  // R10: irq needs a pending flag and the interrupt enable one cycle earlier
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(pend) && $past(cfg.irq_en) && $past(cfg.pin_en)));

endmodule

bind gpio_slice gpio_slice_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tick_1ms(tick_1ms), .pad_oe(pad_oe), .irq(irq),
  .pend(pend_q), .filt(filt_lvl), .clr(clr_pulse), .cfg(cfg_q), .thr(thr_q)
);

// File: tb/tb_gpio_slice.sv
module tb_gpio_slice;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              pad_in = 1'b0;
  logic              tick_1ms = 1'b0;
  logic              pad_o, pad_oe, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_slice dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .tick_1ms(tick_1ms), .pad_o(pad_o), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[ADDR_W-1:0];
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pad(input logic v);
    @(negedge clk);
    pad_in = v;
    idle(6);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h14, 32'h1);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check({pad_o, pad_oe, irq}, 0, "R1 outputs");
    rd(8'h00, d); check(d, 0, "R1 cfg");
    rd(8'h04, d); check(d, 0, "R1 thr");
    rd(8'h08, d); check(d, 0, "R1 input");
    rd(8'h0C, d); check(d, 0, "R1 float");
    rd(8'h10, d); check(d, 0, "R1 oval");
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FF7E); rd(8'h00, d); check(d, 32'h7E, "R2 cfg");
    wr(8'h04, 32'h1234_56A5); rd(8'h04, d); check(d, 32'hA5, "R2 thr");
    wr(8'h0C, 32'h3);         rd(8'h0C, d); check(d, 32'h1, "R2 float");
    wr(8'h10, 32'h1);         rd(8'h10, d); check(d, 32'h1, "R2 oval");
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h0C, 0); wr(8'h10, 0);
  endtask

  task automatic t_drive();
    wr(8'h10, 32'h1); wr(8'h00, 32'h3); idle(2);
    check({pad_oe, pad_o}, 2'b11, "R3 drive enabled");
    wr(8'h0C, 32'h1); idle(2);
    check(pad_oe, 0, "R3 float");
    wr(8'h0C, 32'h0); wr(8'h00, 32'h1); idle(2);
    check(pad_oe, 0, "R3 input dir");
    wr(8'h00, 32'h2); idle(2);
    check(pad_oe, 0, "R3 pin disabled");
    wr(8'h10, 32'h0); idle(2);
    check(pad_o, 0, "R3 value low");
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(8'h00, 32'h1);
    pad(1'b1); rd(8'h08, d); check(d, 1, "R4 bypass high");
    wr(8'h00, 32'h21); wr(8'h04, 0);
    pad(1'b0); rd(8'h08, d); check(d, 0, "R4 zero threshold");
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    wr(8'h00, 32'h21); wr(8'h04, 32'd3);
    pad(1'b1); tick(); tick();
    rd(8'h08, d); check(d, 0, "R5 before threshold");
    tick(); idle(1);
    rd(8'h08, d); check(d, 1, "R5 at threshold");
    pad(1'b0); tick(); tick();
    pad(1'b1); pad(1'b0); tick(); tick();
    rd(8'h08, d); check(d, 1, "R5 glitch restarts count");
    tick(); idle(1);
    rd(8'h08, d); check(d, 0, "R5 after restart");
    wr(8'h00, 32'h1); wr(8'h04, 0);
  endtask

  task automatic t_single_edge();
    wr(8'h00, 32'h59); clear_all();
    pad(1'b1); check(irq, 1, "R6 rising");
    clear_all(); check(irq, 0, "R9 clear");
    pad(1'b0); check(irq, 0, "R6 falling ignored");
    wr(8'h00, 32'h49);
    pad(1'b1); check(irq, 0, "R6 rising ignored");
    pad(1'b0); check(irq, 1, "R6 falling");
    wr(8'h14, 32'h0); idle(2);
    check(irq, 1, "R9 zero write ignored");
    clear_all();
  endtask

  task automatic t_both();
    wr(8'h00, 32'h4D); clear_all();
    pad(1'b1); check(irq, 1, "R7 rise");
    clear_all();
    pad(1'b0); check(irq, 1, "R7 fall");
    clear_all();
  endtask

  task automatic t_level();
    wr(8'h00, 32'h55); idle(4); check(irq, 0, "R8 inactive level");
    pad(1'b1); check(irq, 1, "R8 high");
    clear_all(); check(irq, 1, "R8 clear while held");
    pad(1'b0); check(irq, 1, "R8 sticky after release");
    clear_all(); check(irq, 0, "R8 cleared after release");
    wr(8'h00, 32'h45); idle(4); check(irq, 1, "R8 low level");
    wr(8'h00, 32'h01); clear_all();
  endtask

  task automatic t_gating();
    wr(8'h00, 32'h41);
    pad(1'b1); pad(1'b0); check(irq, 0, "R10 mode none");
    wr(8'h00, 32'h19);
    pad(1'b1); check(irq, 0, "R10 masked");
    wr(8'h00, 32'h59); idle(2); check(irq, 1, "R10 unmasked shows pending");
    clear_all(); pad(1'b0);
    wr(8'h00, 32'h58);
    pad(1'b1); wr(8'h00, 32'h59); idle(2);
    check(irq, 0, "R11 disabled pin detects nothing");
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_drive();
    t_input();
    t_debounce();
    t_single_edge();
    t_both();
    t_level();
    t_gating();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule